// File: doc/BRIEF.md
# Temperature Alarm Window Event Logic

This block takes a stream of temperature samples and compares each one against three programmable trip points: an upper and a lower bound that together form an alarm window, and a separate critical limit. Each comparison drives a status flag. A flag sets as soon as its limit is crossed. On the way back it clears only after the temperature has moved past the limit by a programmable hysteresis margin, so a reading that sits near a limit does not make the flag toggle.

The flags feed an event output that works in one of two modes. In comparator mode the output follows the window flags directly. In interrupt mode it latches when either window flag rises, and a clear request releases it. A critical crossing drives the output in both modes and cannot be cleared by software. The output stays asserted until the temperature falls back below the critical limit minus the hysteresis. The pin level can be set active-high or active-low, and it can be switched off. Temperature sensing, serial register access and the alert response protocol are all handled outside this block.

Top module: `temp_window_alarm`

## Requirements
- R1: Temperature and limit words are compared using only bits 12:0, read as a two's-complement value in 1/16 °C steps (for example 0x0550 is +85 °C and 0x1EC0 is −20 °C). Bits 15:13 have no effect on any output.
- R2: The above-upper flag sets on the clock edge at which a sample with valid high is greater than the upper limit. While valid is low, none of the three flags changes.
- R3: Once above-upper or above-critical is set, it stays set until a valid sample is less than or equal to its limit minus H. H is given by the 2-bit hysteresis code: 0 → 0, 1 → 24 (1.5 °C), 2 → 48, 3 → 96 LSB.
- R4: The below-lower flag sets on a valid sample less than the lower limit. It clears on a valid sample greater than or equal to the lower limit plus H.
- R5: In comparator mode (int_mode = 0), the event condition is the OR of the three flags.
- R6: In interrupt mode (int_mode = 1), an event latch sets on the edge at which above-upper or below-lower rises. It holds until evt_clear is high at an edge. If a rise and a clear occur at the same edge, the set wins. The event condition is the latch OR above-critical.
- R7: While above-critical is set, the event condition is active in both modes, whatever evt_clear does.
- R8: With out_en = 1, event_pin = event condition XOR pol, so pol = 0 means active-high. With out_en = 0, event_pin equals pol, the inactive level.
- R9: Synchronous reset clears all three flags and the event latch, so event_pin equals pol after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_in | input | 16 | Temperature sample |
| temp_valid | input | 1 | Sample strobe |
| upper_lim | input | 16 | Upper window limit |
| lower_lim | input | 16 | Lower window limit |
| crit_lim | input | 16 | Critical limit |
| int_mode | input | 1 | 1 = interrupt (latched), 0 = comparator |
| pol | input | 1 | Event polarity (0 = active-high) |
| out_en | input | 1 | Event output enable |
| hyst_sel | input | 2 | Hysteresis code |
| evt_clear | input | 1 | Clear request for the interrupt latch |
| event_pin | output | 1 | Event output level |
| above_upper | output | 1 | Temperature above the upper limit |
| below_lower | output | 1 | Temperature below the lower limit |
| above_crit | output | 1 | Temperature above the critical limit |

## Verification
The bench builds the block with the package defaults: a 16-bit word, a 13-bit signed field and a 15-bit comparison width. The wider comparison width means that a limit at either end of the field, plus or minus the largest hysteresis of 96, cannot wrap. Random samples are placed close to the three limits, with bits 15:13 set at random. This places many samples exactly on a threshold or on a hysteresis edge, under every hysteresis code, both modes and both polarities.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;
    localparam int TEMP_W  = 16;
    localparam int FIELD_W = 13;
    localparam int GUARD_W = 2;
    localparam int CMP_W   = FIELD_W + GUARD_W;
    localparam int HYST_W  = 2;
    localparam int HYST_UNIT = 12;
    localparam int NTRIP   = 3;

    typedef logic signed [CMP_W-1:0] cmp_t;

    typedef enum int {
        TRIP_UPPER = 0,
        TRIP_LOWER = 1,
        TRIP_CRIT  = 2
    } trip_idx_e;

    typedef struct packed {
        logic crit;
        logic lower;
        logic upper;
    } trip_flags_t;

    // Sign-extend the low signed field of a register word into compare width.
    function automatic cmp_t field_to_cmp(input logic [TEMP_W-1:0] word);
        return cmp_t'({{GUARD_W{word[FIELD_W-1]}}, word[FIELD_W-1:0]});
    endfunction

    // Hysteresis code 0 -> 0, k -> HYST_UNIT << k (24, 48, 96 LSB).
    function automatic cmp_t hyst_lsb(input logic [HYST_W-1:0] code);
        cmp_t h;
        h = '0;
        if (code != '0) h = cmp_t'(HYST_UNIT) <<< code;
        return h;
    endfunction
endpackage

// File: rtl/temp_alarm_trip.sv
module temp_alarm_trip
    import temp_alarm_pkg::*;
#(
    parameter bit ABOVE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  cmp_t temp,
    input  cmp_t limit,
    input  cmp_t hyst,
    output logic flag_q,
    output logic flag_d
);
    logic set_c;
    logic hold_c;

    generate
        if (ABOVE) begin : g_above
            always_comb begin
                set_c  = temp > limit;
                hold_c = temp > (limit - hyst);
            end
        end else begin : g_below
            always_comb begin
                set_c  = temp < limit;
                hold_c = temp < (limit + hyst);
            end
        end
    endgenerate

    always_comb begin
        flag_d = flag_q;
        if (sample_en) flag_d = flag_q ? hold_c : set_c;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end
endmodule

// File: rtl/temp_alarm_event.sv
module temp_alarm_event
    import temp_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  trip_flags_t flags_q,
    input  trip_flags_t flags_d,
    input  logic        int_mode,
    input  logic        pol,
    input  logic        out_en,
    input  logic        evt_clear,
    output logic        event_pin
);
    logic latch_q;
    logic win_rise;
    logic active;

    assign win_rise = (flags_d.upper & ~flags_q.upper) |
                      (flags_d.lower & ~flags_q.lower);

    always_ff @(posedge clk) begin
        if (rst)            latch_q <= 1'b0;
        else if (win_rise)  latch_q <= 1'b1;
        else if (evt_clear) latch_q <= 1'b0;
    end

    always_comb begin
        active = flags_q.crit |
                 (int_mode ? latch_q : (flags_q.upper | flags_q.lower));
        event_pin = out_en ? (active ^ pol) : pol;
    end
endmodule

// File: rtl/temp_window_alarm.sv
module temp_window_alarm
    import temp_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_in,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] upper_lim,
    input  logic [TEMP_W-1:0] lower_lim,
    input  logic [TEMP_W-1:0] crit_lim,
    input  logic              int_mode,
    input  logic              pol,
    input  logic              out_en,
    input  logic [HYST_W-1:0] hyst_sel,
    input  logic              evt_clear,
    output logic              event_pin,
    output logic              above_upper,
    output logic              below_lower,
    output logic              above_crit
);
    cmp_t        temp_c;
    cmp_t        hyst_c;
    cmp_t        lim_c [NTRIP];
    logic [NTRIP-1:0] fq;
    logic [NTRIP-1:0] fd;
    trip_flags_t flags_q;
    trip_flags_t flags_d;

    always_comb begin
        temp_c            = field_to_cmp(temp_in);
        hyst_c            = hyst_lsb(hyst_sel);
        lim_c[TRIP_UPPER] = field_to_cmp(upper_lim);
        lim_c[TRIP_LOWER] = field_to_cmp(lower_lim);
        lim_c[TRIP_CRIT]  = field_to_cmp(crit_lim);
    end

    generate
        for (genvar i = 0; i < NTRIP; i++) begin : g_trip
            temp_alarm_trip #(
                .ABOVE(i != TRIP_LOWER)
            ) u_trip (
                .clk       (clk),
                .rst       (rst),
                .sample_en (temp_valid),
                .temp      (temp_c),
                .limit     (lim_c[i]),
                .hyst      (hyst_c),
                .flag_q    (fq[i]),
                .flag_d    (fd[i])
            );
        end
    endgenerate

    always_comb begin
        flags_q.upper = fq[TRIP_UPPER];
        flags_q.lower = fq[TRIP_LOWER];
        flags_q.crit  = fq[TRIP_CRIT];
        flags_d.upper = fd[TRIP_UPPER];
        flags_d.lower = fd[TRIP_LOWER];
        flags_d.crit  = fd[TRIP_CRIT];
    end

    temp_alarm_event u_event (
        .clk       (clk),
        .rst       (rst),
        .flags_q   (flags_q),
        .flags_d   (flags_d),
        .int_mode  (int_mode),
        .pol       (pol),
        .out_en    (out_en),
        .evt_clear (evt_clear),
        .event_pin (event_pin)
    );

    assign above_upper = flags_q.upper;
    assign below_lower = flags_q.lower;
    assign above_crit  = flags_q.crit;
endmodule

// File: rtl/temp_window_alarm_chk.sv
module temp_window_alarm_chk (
    input logic clk,
    input logic rst,
    input logic temp_valid,
    input logic int_mode,
    input logic pol,
    input logic out_en,
    input logic event_pin,
    input logic above_upper,
    input logic below_lower,
    input logic above_crit
);
    assert_flags_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !temp_valid |=> $stable({above_upper, below_lower, above_crit}));

    assert_cmp_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!int_mode && out_en && !above_upper && !below_lower && !above_crit)
        |-> (event_pin == pol));

    assert_int_rise_R6: assert property (@(posedge clk) disable iff (rst)
        (int_mode && out_en && ($rose(above_upper) || $rose(below_lower)))
        |-> (event_pin != pol));

    assert_crit_active_R7: assert property (@(posedge clk) disable iff (rst)
        (above_crit && out_en) |-> (event_pin != pol));

    assert_out_off_R8: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (event_pin == pol));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!above_upper && !below_lower && !above_crit));
endmodule

bind temp_window_alarm temp_window_alarm_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .temp_valid  (temp_valid),
    .int_mode    (int_mode),
    .pol         (pol),
    .out_en      (out_en),
    .event_pin   (event_pin),
    .above_upper (above_upper),
    .below_lower (below_lower),
    .above_crit  (above_crit)
);

// File: tb/temp_window_alarm_test.sv
`timescale 1ns/1ps
module temp_window_alarm_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] temp_in = '0;
    logic        temp_valid = 1'b0;
    logic [15:0] upper_lim = '0, lower_lim = '0, crit_lim = '0;
    logic        int_mode = 1'b0, pol = 1'b0, out_en = 1'b0;
    logic [1:0]  hyst_sel = '0;
    logic        evt_clear = 1'b0;
    logic        event_pin, above_upper, below_lower, above_crit;

    int errors = 0;
    int checks = 0;
    bit exp_up = 0, exp_lo = 0, exp_cr = 0, exp_lat = 0;

    always #4 clk = ~clk;

    temp_window_alarm uut (
        .clk(clk), .rst(rst), .temp_in(temp_in), .temp_valid(temp_valid),
        .upper_lim(upper_lim), .lower_lim(lower_lim), .crit_lim(crit_lim),
        .int_mode(int_mode), .pol(pol), .out_en(out_en), .hyst_sel(hyst_sel),
        .evt_clear(evt_clear), .event_pin(event_pin), .above_upper(above_upper),
        .below_lower(below_lower), .above_crit(above_crit)
    );

    function automatic int f13(input logic [15:0] w);
        int x;
        x = int'(w & 16'h1FFF);
        if (x >= 4096) x = x - 8192;
        return x;
    endfunction

    function automatic int hval(input logic [1:0] c);
        return (c == 0) ? 0 : (12 << c);
    endfunction

    function automatic bit exp_pin();
        bit act;
        act = exp_cr | (int_mode ? exp_lat : (exp_up | exp_lo));
        return out_en ? (act ^ pol) : pol;
    endfunction

    function automatic logic [15:0] enc(input int v);
        return 16'(v) & 16'h1FFF;
    endfunction

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        int t, h;
        bit nu, nl, nc, rise;
        t = f13(temp_in);
        h = hval(hyst_sel);
        nu = exp_up; nl = exp_lo; nc = exp_cr;
        if (temp_valid) begin
            nu = exp_up ? (t > f13(upper_lim) - h) : (t > f13(upper_lim));
            nl = exp_lo ? (t < f13(lower_lim) + h) : (t < f13(lower_lim));
            nc = exp_cr ? (t > f13(crit_lim) - h)  : (t > f13(crit_lim));
        end
        rise = (nu & !exp_up) | (nl & !exp_lo);
        if (rise) exp_lat = 1;
        else if (evt_clear) exp_lat = 0;
        exp_up = nu; exp_lo = nl; exp_cr = nc;
    endtask

    task automatic step(input string tag, input logic [15:0] t,
                        input bit v, input bit clr);
        temp_in = t; temp_valid = v; evt_clear = clr;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " above_upper R2"}, above_upper, exp_up);
        check({tag, " below_lower R4"}, below_lower, exp_lo);
        check({tag, " above_crit R3"}, above_crit, exp_cr);
        check({tag, " event_pin R8"}, event_pin, exp_pin());
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("reset R9 up", above_upper, 1'b0);
        check("reset R9 lo", below_lower, 1'b0);
        check("reset R9 cr", above_crit, 1'b0);
        check("reset R9 pin", event_pin, pol);

        upper_lim = 16'h0550; lower_lim = enc(-320); crit_lim = 16'h05F0;
        out_en = 1; hyst_sel = 2'd1; int_mode = 0; pol = 0;
        step("R1 below limit", 16'h0540, 1, 0);
        step("R1 upper bits ignored", 16'hE551, 1, 0);
        check("R1 flag set via field", above_upper, 1'b1);
        step("R2 no valid", 16'h0000, 0, 0);
        check("R2 held without valid", above_upper, 1'b1);
        step("R3 inside hyst", 16'h0539, 1, 0);
        check("R3 still set", above_upper, 1'b1);
        step("R3 at hyst edge", 16'h0538, 1, 0);
        check("R3 cleared", above_upper, 1'b0);
        check("R5 comparator idle", event_pin, 1'b0);
        step("R4 below", enc(-321), 1, 0);
        check("R4 set", below_lower, 1'b1);
        step("R4 inside hyst", enc(-297), 1, 0);
        check("R4 still set", below_lower, 1'b1);
        step("R4 at hyst edge", enc(-296), 1, 0);
        check("R4 cleared", below_lower, 1'b0);
        int_mode = 1;
        step("R6 rise", 16'h0560, 1, 0);
        step("R6 back inside", 16'h0100, 1, 0);
        check("R6 latched", event_pin, 1'b1);
        step("R6 clear", 16'h0100, 0, 1);
        check("R6 released", event_pin, 1'b0);
        step("R6 set beats clear", 16'h0560, 1, 1);
        check("R6 set wins", event_pin, 1'b1);
        step("R7 crit", 16'h05F1, 1, 0);
        step("R7 clear ignored", 16'h05F1, 0, 1);
        check("R7 stays", event_pin, 1'b1);
        pol = 1;
        step("R8 polarity", 16'h05F1, 0, 0);
        check("R8 active low", event_pin, 1'b0);
        out_en = 0;
        step("R8 disabled", 16'h05F1, 0, 0);
        check("R8 inactive level", event_pin, 1'b1);

        for (int n = 0; n < 4000; n++) begin
            int base, off;
            logic [15:0] t;
            if (n % 64 == 0) begin
                int_mode = 1'($urandom); pol = 1'($urandom);
                out_en = 1'($urandom); hyst_sel = 2'($urandom);
                upper_lim = enc(int'($urandom_range(0, 800)));
                lower_lim = enc(-int'($urandom_range(0, 800)));
                crit_lim  = enc(f13(upper_lim) + int'($urandom_range(0, 200)));
            end
            case ($urandom_range(0, 2))
                0: base = f13(upper_lim);
                1: base = f13(lower_lim);
                default: base = f13(crit_lim);
            endcase
            off = int'($urandom_range(0, 240)) - 120;
            t = enc(base + off) | {3'($urandom), 13'h0};
            step("rnd R1 R3 R5 R6 R7", t, ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 7) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule